// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This unit clamps a wide intermediate value into a signed or unsigned field of 8, 16 or 32 bits. It can also perform a 64-bit signed add that saturates instead of wrapping. Before a signed clamp it can apply one of four rounding rules: a fixed half-LSB bias for 16-bit fractions, convergent increment, rounding at a chosen bit boundary, and halving with round-up. The result is combinational and appears in the same cycle as the operands. It is always presented as a 64-bit word, sign-extended for signed modes and zero-extended for unsigned mode.

A sticky overflow bit records that a clamp has happened. It is set on a clock edge when `go` is high and the current operation clamped. The arithmetic never clears it. Only `ovf_clr` or reset does.

Top module: `sat_alu`

## Requirements
- R1: Signed clamp (op 0): a value whose low N bits, sign-extended, reproduce it passes unchanged. Otherwise a negative value gives -2^(N-1) and a non-negative one gives 2^(N-1)-1.
- R2: Unsigned clamp (op 1): a value whose low N bits, zero-extended, reproduce it passes unchanged. Otherwise a negative value gives 0 and a non-negative one gives 2^N-1, zero-extended to 64 bits.
- R3: `wsel` picks N: 0 gives 8, 1 gives 16, 2 gives 32. Signed results are sign-extended to 64 bits. Ops 6 and 7 act as op 0.
- R4: With `wsel` = 3 the result is the 64-bit sum a+b, whatever `op` is. When the operand sign bits differ, the wrapped sum is returned as-is.
- R5: With `wsel` = 3, operands of equal sign whose sum changes sign clamp. A negative raw sum gives 0x7FFFFFFFFFFFFFFF and a non-negative one gives 0x8000000000000000.
- R6: Op 2 adds 0x8000 to `a`, then applies the signed clamp of R1.
- R7: Op 3 adds 1 to `a` only when its two lowest bits are both 1, then applies the signed clamp.
- R8: Op 4 adds 1<<(`rnd_n`-1) to `a` when `rnd_n` is nonzero, and leaves `a` unchanged when `rnd_n` is 0. It then applies the signed clamp.
- R9: Op 5 computes (a+1) arithmetically shifted right by one, then applies the signed clamp.
- R10: `ovf_flag` is set on a clock edge where `go` is high and the operation clamped. Once set, it stays set until cleared.
- R11: `ovf_clr` clears `ovf_flag` on the next edge and takes priority over a simultaneous set. A clamping operation with `go` low leaves the flag unchanged.
- R12: `ovf_flag` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Lets a clamp this cycle set the overflow bit |
| ovf_clr | input | 1 | Synchronous clear of the overflow bit |
| op | input | 3 | Operation: 0 signed, 1 unsigned, 2 fixed round, 3 convergent, 4 boundary, 5 halving |
| wsel | input | 2 | Field width 8/16/32, or 3 for the 64-bit add |
| rnd_n | input | 6 | Boundary bit position for op 4 |
| a | input | 64 | First operand / value to clamp |
| b | input | 64 | Second operand of the add |
| result | output | 64 | Clamped or summed result |
| ovf_flag | output | 1 | Sticky overflow status |

## Verification
Each clamp mode is driven exactly at and one step past both limits of each width. This separates an off-by-one bound from a correct one, and a signed test from an unsigned one. The add is tried with mixed-sign operands at the extremes, where wrapping is legal, and with same-sign operands that overflow in each direction. This exposes a swapped clamp polarity. Each rounding rule is given inputs on both sides of its trigger: low bits 11 against 10, boundary 0 against nonzero, and odd against even negative values for halving. These are followed by a long random mix checked each cycle against an exact-range model. Flag sequences cover stickiness, `go` held low, and a clear that coincides with a clamp.

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int DW = 64,
  parameter int NW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          ovf_clr,
  input  logic [2:0]    op,
  input  logic [1:0]    wsel,
  input  logic [NW-1:0] rnd_n,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] result,
  output logic          ovf_flag
);

  localparam int EW = DW + 1;
  localparam logic [2:0] OP_SATU  = 3'd1;
  localparam logic [2:0] OP_RFIX  = 3'd2;
  localparam logic [2:0] OP_RCONV = 3'd3;
  localparam logic [2:0] OP_RBND  = 3'd4;
  localparam logic [2:0] OP_RHALF = 3'd5;

  logic signed [EW-1:0] ax, pre, sx, uz, lim_hi, lim_lo, umax;
  logic [6:0]    w;
  logic [DW-1:0] sat_res, add_res, sum;
  logic          sat_clamp, add_clamp, clamp, add_mode;

  assign ax       = {a[DW-1], a};
  assign w        = 7'd8 << wsel;
  assign add_mode = (wsel == 2'b11);

  always_comb begin
    case (op)
      OP_RFIX:  pre = ax + EW'(32768);
      OP_RCONV: pre = ax + {{(EW-1){1'b0}}, &a[1:0]};
      OP_RBND:  pre = (rnd_n == '0) ? ax : ax + (EW'(1) << (rnd_n - NW'(1)));
      OP_RHALF: pre = $signed(ax + EW'(1)) >>> 1;
      default:  pre = ax;
    endcase
  end

  always_comb begin
    sx     = (pre <<< (EW - int'(w))) >>> (EW - int'(w));
    lim_hi = (EW'(1) <<< (w - 7'd1)) - EW'(1);
    lim_lo = -lim_hi - EW'(1);
    umax   = (EW'(1) <<< w) - EW'(1);
    uz     = pre & umax;
    sat_clamp = 1'b0;
    sat_res   = pre[DW-1:0];
    if (op == OP_SATU) begin
      if (uz != pre) begin
        sat_clamp = 1'b1;
        sat_res   = pre[EW-1] ? '0 : umax[DW-1:0];
      end
    end else if (sx != pre) begin
      sat_clamp = 1'b1;
      sat_res   = pre[EW-1] ? lim_lo[DW-1:0] : lim_hi[DW-1:0];
    end
  end

  assign sum       = a + b;
  assign add_clamp = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
  assign add_res   = !add_clamp ? sum
                   : sum[DW-1]  ? {1'b0, {(DW-1){1'b1}}}
                   :              {1'b1, {(DW-1){1'b0}}};

  assign result = add_mode ? add_res : sat_res;
  assign clamp  = add_mode ? add_clamp : sat_clamp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             ovf_flag <= 1'b0;
    else if (ovf_clr)       ovf_flag <= 1'b0;
    else if (go && clamp)   ovf_flag <= 1'b1;

  p_clr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> !ovf_flag);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);
  p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go && clamp && !ovf_clr |=> ovf_flag);
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !go && !ovf_flag |=> !ovf_flag);
  p_s8_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd0 && wsel == 2'b00 && $signed(a) > 64'sd127 |-> result == DW'(127));
  p_add_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    add_mode && !a[DW-1] && !b[DW-1] |-> !result[DW-1]);
  p_add_mix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    add_mode && (a[DW-1] != b[DW-1]) |-> result == a + b);

endmodule

// File: tb/sat_alu_bench.sv
module sat_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0, ovf_clr = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  wsel = '0;
  logic [5:0]  rnd_n = '0;
  logic [63:0] a = '0, b = '0;
  logic [63:0] result;
  logic        ovf_flag;
  int checks = 0, fails = 0;
  logic model_flag = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sat_alu u_sat_alu (.clk(clk), .rst_n(rst_n), .go(go), .ovf_clr(ovf_clr), .op(op),
    .wsel(wsel), .rnd_n(rnd_n), .a(a), .b(b), .result(result), .ovf_flag(ovf_flag));

  function automatic logic [63:0] model_out(input logic [2:0] o, input logic [1:0] ws,
      input logic [5:0] n, input logic [63:0] x, input logic [63:0] y, output logic cl);
    logic signed [65:0] v, s, lo, hi, um;
    int wd;
    cl = 1'b0;
    v  = $signed({{2{x[63]}}, x});
    if (ws == 2'b11) begin
      s = v + $signed({{2{y[63]}}, y});
      if (s > 66'sh0_7FFF_FFFF_FFFF_FFFF) begin cl = 1; return 64'h7FFF_FFFF_FFFF_FFFF; end
      if (s < -66'sh0_8000_0000_0000_0000) begin cl = 1; return 64'h8000_0000_0000_0000; end
      return s[63:0];
    end
    case (o)
      3'd2: v = v + 66'sd32768;
      3'd3: if (x[1:0] == 2'b11) v = v + 66'sd1;
      3'd4: if (n != 0) v = v + (66'sd1 <<< (n - 1));
      3'd5: v = (v + 66'sd1) >>> 1;
      default: ;
    endcase
    wd = 8 << ws;
    if (o == 3'd1) begin
      um = (66'sd1 <<< wd) - 66'sd1;
      if (v < 0)  begin cl = 1; return 64'd0; end
      if (v > um) begin cl = 1; return um[63:0]; end
      return v[63:0];
    end
    hi = (66'sd1 <<< (wd - 1)) - 66'sd1;
    lo = -hi - 66'sd1;
    if (v > hi) begin cl = 1; return hi[63:0]; end
    if (v < lo) begin cl = 1; return lo[63:0]; end
    return v[63:0];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [2:0] o, input logic [1:0] ws,
      input logic [5:0] n, input logic [63:0] x, input logic [63:0] y,
      input logic g, input logic c);
    logic cl;
    logic [63:0] e;
    op = o; wsel = ws; rnd_n = n; a = x; b = y; go = g; ovf_clr = c;
    #5;
    e = model_out(o, ws, n, x, y, cl);
    check(tag, result, e);
    @(posedge clk);
    if (c) model_flag = 1'b0;
    else if (g && cl) model_flag = 1'b1;
    #2;
    check({tag, " flag"}, {63'd0, ovf_flag}, {63'd0, model_flag});
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset flag", {63'd0, ovf_flag}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 flag after release", {63'd0, ovf_flag}, 64'd0);
    run("R1 s8 pass 127", 0, 0, 0, 64'd127, 0, 1, 0);
    run("R1 s8 pass -128", 0, 0, 0, -64'd128, 0, 1, 0);
    run("R11 go low no set", 0, 0, 0, 64'd128, 0, 0, 0);
    run("R1 s8 clamp 128", 0, 0, 0, 64'd128, 0, 1, 0);
    run("R10 sticky", 0, 0, 0, 64'd5, 0, 1, 0);
    run("R11 clear", 0, 0, 0, 64'd5, 0, 1, 1);
    run("R11 clear beats set", 0, 0, 0, -64'd129, 0, 1, 1);
    run("R2 u16 pass", 1, 1, 0, 64'd65535, 0, 1, 0);
    run("R2 u16 clamp high", 1, 1, 0, 64'd65536, 0, 1, 1);
    run("R2 u16 negative", 1, 1, 0, -64'd1, 0, 1, 1);
    run("R2 u32 pass", 1, 2, 0, 64'hFFFF_FFFF, 0, 1, 1);
    run("R3 s32 clamp", 0, 2, 0, 64'h8000_0000, 0, 1, 1);
    run("R3 s16 neg clamp", 0, 1, 0, -64'd40000, 0, 1, 1);
    run("R3 op7 as signed", 7, 0, 0, 64'd300, 0, 1, 1);
    run("R4 mixed signs", 0, 3, 0, 64'h7FFF_FFFF_FFFF_FFFF, -64'd1, 1, 1);
    run("R4 mixed min", 2, 3, 0, 64'h8000_0000_0000_0000, 64'd5, 1, 1);
    run("R5 pos overflow", 0, 3, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1, 1);
    run("R5 neg overflow", 0, 3, 0, 64'h8000_0000_0000_0000, -64'd1, 1, 0);
    run("R6 fixed round clamp", 2, 1, 0, 64'h1234, 0, 1, 1);
    run("R6 fixed round pass", 2, 2, 0, 64'h10000, 0, 1, 1);
    run("R7 conv low 11", 3, 0, 0, 64'd7, 0, 1, 1);
    run("R7 conv low 10", 3, 0, 0, 64'd6, 0, 1, 1);
    run("R7 conv to clamp", 3, 0, 0, 64'd127, 0, 1, 1);
    run("R8 boundary n0", 4, 0, 0, 64'd5, 0, 1, 1);
    run("R8 boundary n4", 4, 0, 4, 64'd5, 0, 1, 1);
    run("R8 boundary n63", 4, 2, 63, 64'd1, 0, 1, 1);
    run("R9 halve 7", 5, 0, 0, 64'd7, 0, 1, 1);
    run("R9 halve -3", 5, 0, 0, -64'd3, 0, 1, 1);
    run("R9 halve -4", 5, 0, 0, -64'd4, 0, 1, 1);
    run("R9 halve max", 5, 2, 0, 64'h7FFF_FFFF_FFFF_FFFF, 0, 1, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 3 == 1) ra = {{40{ra[23]}}, ra[23:0]};
      if (i % 3 == 2) ra = {{52{ra[11]}}, ra[11:0]};
      run("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random", 3'($urandom), 2'($urandom),
          6'($urandom), ra, rb, 1'($urandom), ($urandom % 8) == 0);
    end
    done = 1'b1;
    finish_up();
  end
endmodule